// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit executes one bit-level instruction on a byte operand. The caller presents the operand byte, a bit index, the current carry and zero flags and an operation code, and pulses `start` for one cycle. One cycle later the unit pulses `done`. With it, the unit presents the resulting byte and a write-back request. It also presents the new carry and zero flags, each with its own update enable.

The operations fall into three groups. The first group reads, modifies and writes one bit: force it to one, force it to zero, flip it, or copy the carry (or its complement) into it. The second group only reads the bit: test it into Z, load it (or its complement) into C, or combine it (or its complement) with C through AND, OR or XOR. The third group is the two unused codes, which change nothing. Fetching and storing the operand belongs to the surrounding datapath. The unit only says whether the byte has to go back.

Handshake: the operand, control and flag inputs are sampled only in the cycle where `start` is high. Each start produces exactly one `done` pulse one cycle later. There is no back-pressure. The consumer must take the result in the `done` cycle. The byte and flag values stay unchanged until the next start, but `wr_en`, `c_upd` and `z_upd` are high only during `done`. A new start may come in every cycle.

Top module: `bitop_unit`

## Requirements
- R1: Code 0 (set) returns the operand with the bit at `bit_idx` forced to 1, all other bits unchanged, and raises `wr_en`; C and Z are not updated.
- R2: Code 1 (clear) returns the operand with the indexed bit forced to 0, others unchanged, and raises `wr_en`; flags are not updated.
- R3: Code 2 (invert) returns the operand with the indexed bit complemented, others unchanged, and raises `wr_en`; flags are not updated.
- R4: Code 3 (test) returns the operand unchanged with `wr_en` low, raises `z_upd` and sets `z_out` to 1 exactly when the indexed bit is 0.
- R5: Code 4 (load) sets `c_out` to the indexed bit and code 5 (inverted load) to its complement; both raise `c_upd`, keep `wr_en` low and leave the byte unchanged.
- R6: Code 6 (store) writes C into the indexed bit and code 7 (inverted store) writes the complement of C into it; other bits are unchanged, `wr_en` is high and no flag is updated.
- R7: Code 8 sets C to (bit AND C) and code 9 to (NOT bit AND C); `c_upd` high, `wr_en` low, byte unchanged.
- R8: Code 10 sets C to (bit OR C) and code 11 to (NOT bit OR C); `c_upd` high, `wr_en` low, byte unchanged.
- R9: Code 12 sets C to (bit XOR C) and code 13 to (NOT bit XOR C); `c_upd` high, `wr_en` low, byte unchanged.
- R10: Whenever an update enable is low during `done`, the matching flag output equals the flag input sampled at start.
- R11: `done` is high in the cycle right after each cycle with `start` high, and low otherwise; `wr_en`, `c_upd` and `z_upd` are low whenever `done` is low.
- R12: Codes 14 and 15 return the byte unchanged with `wr_en`, `c_upd` and `z_upd` all low.
- R13: After reset, `done`, `wr_en`, `c_upd`, `z_upd`, `c_out`, `z_out` and `dout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; inputs sampled in this cycle |
| op | input | 4 | Operation code (0..13 defined, 14..15 unused) |
| bit_idx | input | IDX_W (3) | Index of the selected bit |
| din | input | DATA_W (8) | Operand byte |
| c_in | input | 1 | Incoming carry flag |
| z_in | input | 1 | Incoming zero flag |
| dout | output | DATA_W (8) | Resulting byte |
| wr_en | output | 1 | Byte must be written back (valid with done) |
| c_out | output | 1 | Resulting carry flag |
| z_out | output | 1 | Resulting zero flag |
| c_upd | output | 1 | Carry updated by this operation (valid with done) |
| z_upd | output | 1 | Zero updated by this operation (valid with done) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default width of 8 data bits. This gives a 3-bit index, so every bit position can be reached. The bench sweeps all eight positions for set, clear, invert, test and both store forms, using operands with the target bit both set and clear. The carry-only operations run over all four combinations of selected bit and incoming carry. Back-to-back starts and the unused codes cover the pulse timing and the flags that must stay unchanged.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [3:0] {
    BOP_SET  = 4'd0,
    BOP_CLR  = 4'd1,
    BOP_INV  = 4'd2,
    BOP_TST  = 4'd3,
    BOP_LD   = 4'd4,
    BOP_ILD  = 4'd5,
    BOP_ST   = 4'd6,
    BOP_IST  = 4'd7,
    BOP_AND  = 4'd8,
    BOP_IAND = 4'd9,
    BOP_OR   = 4'd10,
    BOP_IOR  = 4'd11,
    BOP_XOR  = 4'd12,
    BOP_IXOR = 4'd13
  } bop_e;

  typedef struct packed {
    logic wr;
    logic c_upd;
    logic z_upd;
    logic c_val;
    logic z_val;
  } bop_ctl_t;

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] mask,
  output logic              sel
);
  // one-hot decode of the index, one comparator per bit lane
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign mask[i] = (idx == IDX_W'(i));
  end

  assign sel = |(opnd & mask);
endmodule

// File: rtl/bitop_core.sv
module bitop_core
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] mask,
  input  logic              sel,
  input  logic              c_in,
  input  logic              z_in,
  output logic [DATA_W-1:0] nxt,
  output bop_ctl_t          ctl
);
  logic [DATA_W-1:0] cleared;
  assign cleared = opnd & ~mask;

  always_comb begin
    nxt       = opnd;
    ctl       = '0;
    ctl.c_val = c_in;
    ctl.z_val = z_in;
    case (bop_e'(op))
      BOP_SET: begin nxt = opnd | mask;  ctl.wr = 1'b1; end
      BOP_CLR: begin nxt = cleared;      ctl.wr = 1'b1; end
      BOP_INV: begin nxt = opnd ^ mask;  ctl.wr = 1'b1; end
      BOP_TST: begin ctl.z_upd = 1'b1; ctl.z_val = ~sel; end
      BOP_LD:  begin ctl.c_upd = 1'b1; ctl.c_val = sel;  end
      BOP_ILD: begin ctl.c_upd = 1'b1; ctl.c_val = ~sel; end
      BOP_ST: begin
        nxt    = c_in ? (cleared | mask) : cleared;
        ctl.wr = 1'b1;
      end
      BOP_IST: begin
        nxt    = c_in ? cleared : (cleared | mask);
        ctl.wr = 1'b1;
      end
      BOP_AND:  begin ctl.c_upd = 1'b1; ctl.c_val = sel & c_in;  end
      BOP_IAND: begin ctl.c_upd = 1'b1; ctl.c_val = ~sel & c_in; end
      BOP_OR:   begin ctl.c_upd = 1'b1; ctl.c_val = sel | c_in;  end
      BOP_IOR:  begin ctl.c_upd = 1'b1; ctl.c_val = ~sel | c_in; end
      BOP_XOR:  begin ctl.c_upd = 1'b1; ctl.c_val = sel ^ c_in;  end
      BOP_IXOR: begin ctl.c_upd = 1'b1; ctl.c_val = ~sel ^ c_in; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_outreg.sv
module bitop_outreg
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] nxt,
  input  bop_ctl_t          ctl,
  output logic [DATA_W-1:0] dout,
  output logic              wr_en,
  output logic              c_out,
  output logic              z_out,
  output logic              c_upd,
  output logic              z_upd,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      wr_en <= 1'b0;
      c_out <= 1'b0;
      z_out <= 1'b0;
      c_upd <= 1'b0;
      z_upd <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      dout  <= nxt;
      wr_en <= ctl.wr;
      c_out <= ctl.c_val;
      z_out <= ctl.z_val;
      c_upd <= ctl.c_upd;
      z_upd <= ctl.z_upd;
      done  <= 1'b1;
    end else begin
      wr_en <= 1'b0;
      c_upd <= 1'b0;
      z_upd <= 1'b0;
      done  <= 1'b0;
    end
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] din,
  input  logic              c_in,
  input  logic              z_in,
  output logic [DATA_W-1:0] dout,
  output logic              wr_en,
  output logic              c_out,
  output logic              z_out,
  output logic              c_upd,
  output logic              z_upd,
  output logic              done
);
  logic [DATA_W-1:0] mask;
  logic              sel;
  logic [DATA_W-1:0] nxt;
  bop_ctl_t          ctl;

  bitop_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .idx(bit_idx), .opnd(din), .mask(mask), .sel(sel)
  );

  bitop_core #(.DATA_W(DATA_W)) u_core (
    .op(op), .opnd(din), .mask(mask), .sel(sel),
    .c_in(c_in), .z_in(z_in), .nxt(nxt), .ctl(ctl)
  );

  bitop_outreg #(.DATA_W(DATA_W)) u_oreg (
    .clk(clk), .rst_n(rst_n), .start(start), .nxt(nxt), .ctl(ctl),
    .dout(dout), .wr_en(wr_en), .c_out(c_out), .z_out(z_out),
    .c_upd(c_upd), .z_upd(z_upd), .done(done)
  );
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [3:0]        op,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [DATA_W-1:0] din,
  input logic              c_in,
  input logic              z_in,
  input logic [DATA_W-1:0] dout,
  input logic              wr_en,
  input logic              c_out,
  input logic              z_out,
  input logic              c_upd,
  input logic              z_upd,
  input logic              done
);
  // R11
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R11
  done_only_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R11
  enables_need_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || c_upd || z_upd) |-> done);

  // R1 R2 R3 R6: only the indexed bit may differ from the operand
  other_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (((dout ^ $past(din)) & ~(DATA_W'(1) << $past(bit_idx))) == '0));

  // R4 R5: no write-back means the byte comes back untouched
  no_wr_byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (wr_en || dout == $past(din)));

  // R10
  carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (c_upd || c_out == $past(c_in)));

  // R10
  zero_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (z_upd || z_out == $past(z_in)));

  // R12
  unused_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op[3:1] == 3'b111) |=> (!wr_en && !c_upd && !z_upd));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_idx(bit_idx),
  .din(din), .c_in(c_in), .z_in(z_in), .dout(dout), .wr_en(wr_en),
  .c_out(c_out), .z_out(z_out), .c_upd(c_upd), .z_upd(z_upd), .done(done)
);

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    op = '0;
  logic [IW-1:0] bit_idx = '0;
  logic [DW-1:0] din = '0;
  logic          c_in = 1'b0;
  logic          z_in = 1'b0;
  logic [DW-1:0] dout;
  logic          wr_en, c_out, z_out, c_upd, z_upd, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_idx(bit_idx),
    .din(din), .c_in(c_in), .z_in(z_in), .dout(dout), .wr_en(wr_en),
    .c_out(c_out), .z_out(z_out), .c_upd(c_upd), .z_upd(z_upd), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // issue one operation, return after done has been registered
  task automatic issue(input logic [3:0] o, input logic [IW-1:0] i,
                       input logic [DW-1:0] d, input logic c, input logic z);
    @(negedge clk);
    op = o; bit_idx = i; din = d; c_in = c; z_in = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // full result comparison, enables included
  task automatic expect_all(input string tag, input logic [DW-1:0] ed,
                            input logic ew, input logic ec, input logic ecu,
                            input logic ez, input logic ezu);
    chk({tag, " done"}, done, 1'b1);
    chk({tag, " dout"}, dout, ed);
    chk({tag, " wr_en"}, wr_en, ew);
    chk({tag, " c_out"}, c_out, ec);
    chk({tag, " c_upd"}, c_upd, ecu);
    chk({tag, " z_out"}, z_out, ez);
    chk({tag, " z_upd"}, z_upd, ezu);
  endtask

  task automatic t_reset();
    chk("R13 done", done, 1'b0);
    chk("R13 wr_en", wr_en, 1'b0);
    chk("R13 flags", {c_out, z_out, c_upd, z_upd}, 4'b0);
    chk("R13 dout", dout, '0);
  endtask

  task automatic t_modify();
    for (int i = 0; i < DW; i++) begin
      logic [DW-1:0] m = DW'(1) << i;
      logic [DW-1:0] a = 8'hA5 ^ DW'(i * 37);
      issue(4'd0, IW'(i), a, 1'b1, 1'b0);
      expect_all("R1 set", a | m, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      issue(4'd1, IW'(i), a, 1'b0, 1'b1);
      expect_all("R2 clear", a & ~m, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      issue(4'd2, IW'(i), a, 1'b1, 1'b1);
      expect_all("R3 invert", a ^ m, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic t_test();
    for (int i = 0; i < DW; i++) begin
      logic [DW-1:0] m = DW'(1) << i;
      issue(4'd3, IW'(i), m, 1'b1, 1'b1);
      expect_all("R4 test bit1", m, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      issue(4'd3, IW'(i), ~m, 1'b0, 1'b0);
      expect_all("R4 test bit0", ~m, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    end
  endtask

  task automatic t_load();
    issue(4'd4, 3'd5, 8'h20, 1'b0, 1'b1);
    expect_all("R5 load 1", 8'h20, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    issue(4'd4, 3'd5, 8'hDF, 1'b1, 1'b0);
    expect_all("R5 load 0", 8'hDF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    issue(4'd5, 3'd0, 8'h01, 1'b1, 1'b0);
    expect_all("R5 iload", 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    issue(4'd5, 3'd7, 8'h7F, 1'b0, 1'b0);
    expect_all("R5 iload", 8'h7F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_store();
    for (int i = 0; i < DW; i++) begin
      logic [DW-1:0] m = DW'(1) << i;
      issue(4'd6, IW'(i), 8'h00, 1'b1, 1'b0);
      expect_all("R6 store c1", m, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      issue(4'd6, IW'(i), 8'hFF, 1'b0, 1'b1);
      expect_all("R6 store c0", ~m, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      issue(4'd7, IW'(i), 8'hFF, 1'b1, 1'b0);
      expect_all("R6 istore c1", ~m, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      issue(4'd7, IW'(i), 8'h00, 1'b0, 1'b0);
      expect_all("R6 istore c0", m, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_logic();
    for (int k = 0; k < 4; k++) begin
      logic b = k[1];
      logic c = k[0];
      logic [DW-1:0] a = b ? 8'h48 : 8'h40;
      issue(4'd8, 3'd3, a, c, 1'b1);
      expect_all("R7 and", a, 1'b0, b & c, 1'b1, 1'b1, 1'b0);
      issue(4'd9, 3'd3, a, c, 1'b0);
      expect_all("R7 iand", a, 1'b0, ~b & c, 1'b1, 1'b0, 1'b0);
      issue(4'd10, 3'd3, a, c, 1'b1);
      expect_all("R8 or", a, 1'b0, b | c, 1'b1, 1'b1, 1'b0);
      issue(4'd11, 3'd3, a, c, 1'b0);
      expect_all("R8 ior", a, 1'b0, ~b | c, 1'b1, 1'b0, 1'b0);
      issue(4'd12, 3'd3, a, c, 1'b1);
      expect_all("R9 xor", a, 1'b0, b ^ c, 1'b1, 1'b1, 1'b0);
      issue(4'd13, 3'd3, a, c, 1'b0);
      expect_all("R9 ixor", a, 1'b0, ~b ^ c, 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_unused();
    issue(4'd14, 3'd2, 8'h3C, 1'b1, 1'b0);
    expect_all("R12 code14", 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(4'd15, 3'd6, 8'hC3, 1'b0, 1'b1);
    expect_all("R12 code15", 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R10: flags not named by set keep their inputs
    issue(4'd0, 3'd4, 8'h00, 1'b0, 1'b1);
    expect_all("R10 kept", 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_timing();
    // back-to-back starts, then idle
    @(negedge clk);
    op = 4'd0; bit_idx = 3'd1; din = 8'h00; c_in = 1'b0; z_in = 1'b0; start = 1'b1;
    @(negedge clk);
    chk("R11 first done", done, 1'b1);
    chk("R1 first dout", dout, 8'h02);
    op = 4'd3; bit_idx = 3'd1; din = 8'h00;
    @(negedge clk);
    start = 1'b0;
    chk("R11 second done", done, 1'b1);
    chk("R4 second z", {z_upd, z_out, wr_en}, 3'b110);
    @(negedge clk);
    chk("R11 done drop", done, 1'b0);
    chk("R11 enables drop", {wr_en, c_upd, z_upd}, 3'b000);
    @(negedge clk);
    chk("R11 stays low", done, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modify();
    t_test();
    t_load();
    t_store();
    t_logic();
    t_unused();
    t_timing();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule